// File: doc/BRIEF.md
# Event FIFO DMA sequencer

This block drains buffered event data from a small bank of FIFOs toward a host-side bridge. The host first programs a table of destination addresses, one entry per FIFO source, each with a valid bit. When the host signals that it can take data, the sequencer chooses one non-empty source in rotating order and looks up that source's destination. It then presents the address with a one-cycle start strobe and issues FIFO read enables for as many words as the event's length field gives. It closes each event with a one-cycle stop strobe. A separate path turns broadcast word strobes into per-FIFO write enables.

The controller is a five-state machine. IDLE waits for host readiness and a non-empty source. The IDLE-to-LOOKUP transition latches the arbitration winner. LOOKUP reads the mapper entry. LOOKUP goes to ISSUE on a valid entry. On an invalid entry it returns to IDLE, dropping the request and raising the error flag. ISSUE drives the start strobe and loads the word counter. ISSUE goes to XFER, or directly to STOP for a zero-length event. XFER reads one word per cycle while the host is ready and moves to STOP on the final word. STOP drives the stop strobe and returns to IDLE.

Top module: `edma_seq`

## Requirements
- R1: A mapper write with `map_we` high stores `map_addr` and `map_ok` into entry `map_idx`. A later write to the same entry replaces it, and the next transfer for that source uses the new address.
- R2: While `host_ready` is low in IDLE, no transfer starts: `dma_go` stays low even with sources non-empty.
- R3: Sources whose `fifo_empty` bit is set are skipped. Among the others, the grant rotates: the search starts at the source after the last one granted, and source 0 comes first after reset.
- R4: `dma_go` is high for exactly one cycle per transfer. During that cycle `dma_addr` equals the mapper address of the granted source, and `dma_addr` stays unchanged until `dma_stop`.
- R5: `fifo_ren` has bit s set only for the granted source s, and only in cycles where `host_ready` is high. It drops to zero while `host_ready` is low and resumes when it returns.
- R6: The number of read enables per transfer equals the granted source's length field `evt_len[s*LEN_W +: LEN_W]`. A length of zero gives no read enables.
- R7: `dma_stop` is high for exactly one cycle, in the cycle after the last read enable (or after `dma_go` for length zero). The block then returns to IDLE and can start a new transfer.
- R8: A granted source whose mapper entry has its valid bit clear produces no `dma_go`. The request is dropped, and `map_err` goes high and stays high until reset.
- R9: A cycle with `bcast_strobe` high and select `bcast_sel` gives `fifo_wen` equal to one-hot bit `bcast_sel` in the following cycle. Without a strobe, `fifo_wen` is zero.
- R10: In and just after reset, `dma_go`, `dma_stop`, `fifo_ren`, `fifo_wen` and `map_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Mapper table write strobe |
| map_idx | input | IDX_W | Mapper entry index |
| map_addr | input | ADDR_W | Destination address to store |
| map_ok | input | 1 | Valid bit to store |
| host_ready | input | 1 | Host can accept DMA data |
| dma_addr | output | ADDR_W | Destination address of current transfer |
| dma_go | output | 1 | One-cycle start strobe |
| dma_stop | output | 1 | One-cycle end-of-event strobe |
| fifo_empty | input | NSRC | Per-source FIFO empty flags |
| evt_len | input | NSRC*LEN_W | Per-source event length fields, source s at bits s*LEN_W |
| fifo_ren | output | NSRC | Per-FIFO read clock enables |
| bcast_strobe | input | 1 | Broadcast word present |
| bcast_sel | input | IDX_W | FIFO that receives the broadcast word |
| fifo_wen | output | NSRC | Per-FIFO write clock enables |
| map_err | output | 1 | Sticky invalid-mapper-entry flag |

## Verification
The rotating grant is the hardest behaviour to reach from the ports. Every source keeps requesting until its FIFO is marked empty, so a source left non-empty would be granted again and again. The bench therefore models the FIFOs: each time it sees a start strobe, it marks the granted source empty before the machine returns to IDLE. This lets it raise all four sources at once and observe the full rotation from a non-zero pointer. The same model is used to leave a source with an invalid mapper entry requesting. That source cycles through LOOKUP and back without ever starting a transfer, and the bench then releases it and checks that service resumes at the next source in order.

// File: rtl/edma_pkg.sv
package edma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ISSUE,
        ST_XFER,
        ST_STOP
    } seq_state_e;
endpackage

// File: rtl/edma_rr_arb.sv
module edma_rr_arb #(
    parameter int NSRC  = 4,
    parameter int IDX_W = 2
) (
    input  logic [NSRC-1:0]  req,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    // Scan from farthest to nearest so the nearest candidate after `last` wins.
    always_comb begin
        int cand;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = NSRC; k >= 1; k--) begin
            cand = (int'(last) + k) % NSRC;
            if (req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/edma_map_table.sv
module edma_map_table #(
    parameter int NSRC   = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ok
);
    logic [ADDR_W-1:0] addr_q [NSRC];
    logic [NSRC-1:0]   ok_q;

    for (genvar e = 0; e < NSRC; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[e] <= '0;
                ok_q[e]   <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                addr_q[e] <= wr_addr;
                ok_q[e]   <= wr_ok;
            end
        end
    end

    assign rd_addr = addr_q[rd_idx];
    assign rd_ok   = ok_q[rd_idx];
endmodule

// File: rtl/edma_wclk.sv
module edma_wclk #(
    parameter int NSRC  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [IDX_W-1:0] sel,
    output logic [NSRC-1:0]  wen
);
    for (genvar f = 0; f < NSRC; f++) begin : g_wen
        always_ff @(posedge clk) begin
            if (!rst_n) wen[f] <= 1'b0;
            else        wen[f] <= strobe && (sel == IDX_W'(f));
        end
    end
endmodule

// File: rtl/edma_seq.sv
module edma_seq
    import edma_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  map_we,
    input  logic [IDX_W-1:0]      map_idx,
    input  logic [ADDR_W-1:0]     map_addr,
    input  logic                  map_ok,
    input  logic                  host_ready,
    output logic [ADDR_W-1:0]     dma_addr,
    output logic                  dma_go,
    output logic                  dma_stop,
    input  logic [NSRC-1:0]       fifo_empty,
    input  logic [NSRC*LEN_W-1:0] evt_len,
    output logic [NSRC-1:0]       fifo_ren,
    input  logic                  bcast_strobe,
    input  logic [IDX_W-1:0]      bcast_sel,
    output logic [NSRC-1:0]       fifo_wen,
    output logic                  map_err
);
    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  sel_q, last_q, arb_idx;
    logic              arb_any;
    logic [ADDR_W-1:0] tbl_addr, addr_q;
    logic              tbl_ok;
    logic [LEN_W-1:0]  cnt_q, sel_len;
    logic              err_q;

    edma_rr_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .req(~fifo_empty), .last(last_q), .gnt_idx(arb_idx), .gnt_any(arb_any)
    );

    edma_map_table #(.NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_idx(map_idx),
        .wr_addr(map_addr), .wr_ok(map_ok), .rd_idx(sel_q),
        .rd_addr(tbl_addr), .rd_ok(tbl_ok)
    );

    edma_wclk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_wclk (
        .clk(clk), .rst_n(rst_n), .strobe(bcast_strobe), .sel(bcast_sel), .wen(fifo_wen)
    );

    assign sel_len = evt_len[sel_q*LEN_W +: LEN_W];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (host_ready && arb_any) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = tbl_ok ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:  state_d = (sel_len == '0) ? ST_STOP : ST_XFER;
            ST_XFER:   if (host_ready && cnt_q == LEN_W'(1)) state_d = ST_STOP;
            ST_STOP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            last_q  <= IDX_W'(NSRC - 1);
            addr_q  <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_LOOKUP) sel_q <= arb_idx;
            if (state_q == ST_LOOKUP) begin
                last_q <= sel_q;
                addr_q <= tbl_addr;
                if (!tbl_ok) err_q <= 1'b1;
            end
            if (state_q == ST_ISSUE) cnt_q <= sel_len;
            else if (state_q == ST_XFER && host_ready) cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Output logic
    always_comb begin
        dma_go   = (state_q == ST_ISSUE);
        dma_stop = (state_q == ST_STOP);
        fifo_ren = '0;
        if (state_q == ST_XFER && host_ready) fifo_ren[sel_q] = 1'b1;
    end

    assign dma_addr = addr_q;
    assign map_err  = err_q;
endmodule

// File: rtl/edma_seq_chk.sv
module edma_seq_chk #(
    parameter int NSRC   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic [NSRC-1:0]   fifo_ren,
    input logic [NSRC-1:0]   fifo_wen,
    input logic              dma_go,
    input logic              dma_stop,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              map_err
);
    a_r5_ren_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_ren) |-> host_ready);
    a_r5_ren_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_ren));
    a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        dma_go |=> !dma_go);
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_ren) |=> $stable(dma_addr));
    a_r7_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        dma_stop |=> !dma_stop);
    a_r7_go_stop_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_go && dma_stop));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |=> map_err);
    a_r9_wen_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_wen));
endmodule

bind edma_seq edma_seq_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .fifo_ren(fifo_ren),
    .fifo_wen(fifo_wen), .dma_go(dma_go), .dma_stop(dma_stop),
    .dma_addr(dma_addr), .map_err(map_err)
);

// File: tb/edma_seq_test.sv
module edma_seq_test;
    localparam int NSRC = 4, ADDR_W = 32, LEN_W = 8, IDX_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic map_we = 1'b0, map_ok = 1'b0, host_ready = 1'b0, bcast_strobe = 1'b0;
    logic [IDX_W-1:0] map_idx = '0, bcast_sel = '0;
    logic [ADDR_W-1:0] map_addr = '0, dma_addr;
    logic dma_go, dma_stop, map_err;
    logic [NSRC-1:0] fifo_empty = '1, fifo_ren, fifo_wen;
    logic [NSRC*LEN_W-1:0] evt_len = {8'd2, 8'd0, 8'd5, 8'd3};

    always #4 clk = ~clk;

    edma_seq #(.NSRC(NSRC), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
        .map_addr(map_addr), .map_ok(map_ok), .host_ready(host_ready),
        .dma_addr(dma_addr), .dma_go(dma_go), .dma_stop(dma_stop),
        .fifo_empty(fifo_empty), .evt_len(evt_len), .fifo_ren(fifo_ren),
        .bcast_strobe(bcast_strobe), .bcast_sel(bcast_sel), .fifo_wen(fifo_wen),
        .map_err(map_err)
    );

    typedef struct { int src; logic [ADDR_W-1:0] addr; int len; } exp_t;
    exp_t exp_q[$];
    exp_t cur;
    int checks = 0, failures = 0, go_seen = 0;
    bit active = 0, done = 0;
    int rd_cnt = 0;
    logic [ADDR_W-1:0] map_shadow [NSRC];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int len_of(input int s);
        return int'(evt_len[s*LEN_W +: LEN_W]);
    endfunction

    task automatic wr_map(input int idx, input logic [ADDR_W-1:0] a, input bit ok);
        @(posedge clk); #1;
        map_we = 1'b1; map_idx = IDX_W'(idx); map_addr = a; map_ok = ok;
        @(posedge clk); #1;
        map_we = 1'b0;
        map_shadow[idx] = a;
    endtask

    // Driver side of the scoreboard: record an expected transfer
    task automatic expect_xfer(input int s);
        exp_t e;
        e.src = s; e.addr = map_shadow[s]; e.len = len_of(s);
        exp_q.push_back(e);
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0 || active) @(negedge clk);
    endtask

    // FIFO model: a granted source becomes empty before the next arbitration
    int drain_src = -1;
    always @(posedge clk) begin
        if (drain_src >= 0) begin
            #1 fifo_empty[drain_src] = 1'b1;
            drain_src = -1;
        end
    end

    // Monitor: compare design output against the expectation queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_go) begin
                go_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected dma_go addr", dma_addr, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check(dma_addr == cur.addr, "R4", "go address (R1 mapper)", dma_addr, cur.addr);
                    active = 1; rd_cnt = 0;
                    drain_src = cur.src;
                end
            end
            if (|fifo_ren) begin
                if (!active) check(0, "R5", "read enable outside transfer", fifo_ren, 0);
                else begin
                    if (fifo_ren != NSRC'(1 << cur.src))
                        check(0, "R5", "read enable source", fifo_ren, 1 << cur.src);
                    if (!host_ready) check(0, "R5", "read while not ready", fifo_ren, 0);
                    rd_cnt++;
                end
            end
            if (active && dma_addr != cur.addr)
                check(0, "R4", "address changed mid-transfer", dma_addr, cur.addr);
            if (dma_stop) begin
                if (!active) check(0, "R7", "stop without transfer", 1, 0);
                else begin
                    check(rd_cnt == cur.len, "R6", "read count", rd_cnt, cur.len);
                    check(fifo_ren == '0, "R7", "no read on stop cycle", fifo_ren, 0);
                    active = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) map_shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({dma_go, dma_stop, fifo_ren, fifo_wen, map_err} == '0, "R10", "outputs in reset",
              {dma_go, dma_stop, fifo_ren, fifo_wen, map_err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check({dma_go, dma_stop, fifo_ren, fifo_wen, map_err} == '0, "R10", "outputs after reset",
              {dma_go, dma_stop, fifo_ren, fifo_wen, map_err}, 0);

        for (int i = 0; i < NSRC; i++) wr_map(i, 32'h1000_0000 + 32'(i) * 32'h100, 1'b1);

        // R2: sources pending but host not ready
        @(posedge clk); #1 fifo_empty = 4'b1010;
        repeat (12) @(negedge clk);
        check(go_seen == 0, "R2", "go while host not ready", go_seen, 0);

        // R3/R6: sources 0 and 2, source 2 has zero length
        expect_xfer(0); expect_xfer(2);
        @(posedge clk); #1 host_ready = 1'b1;
        wait_drained();
        check(go_seen == 2, "R3", "transfers for sources 0 and 2", go_seen, 2);

        // R5: pause reads by dropping ready mid-transfer on source 1
        expect_xfer(1);
        @(posedge clk); #1 fifo_empty[1] = 1'b0;
        while (fifo_ren == '0) @(negedge clk);
        @(posedge clk); #1 host_ready = 1'b0;
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            check(fifo_ren == '0, "R5", "reads paused", fifo_ren, 0);
        end
        @(posedge clk); #1 host_ready = 1'b1;
        wait_drained();

        // R1: rewrite entry 0, then R3 rotation from pointer at source 1
        wr_map(0, 32'hCAFE_0000, 1'b1);
        expect_xfer(2); expect_xfer(3); expect_xfer(0); expect_xfer(1);
        @(posedge clk); #1 fifo_empty = 4'b0000;
        wait_drained();
        check(go_seen == 7, "R3", "rotation transfer count", go_seen, 7);

        // R8: invalid entry for source 3
        wr_map(3, 32'hDEAD_0000, 1'b0);
        @(posedge clk); #1 fifo_empty = 4'b0111;
        repeat (12) @(negedge clk);
        check(map_err == 1'b1, "R8", "error flag set", map_err, 1);
        check(go_seen == 7, "R8", "no go for invalid entry", go_seen, 7);
        expect_xfer(0);
        @(posedge clk); #1 fifo_empty = 4'b1110;
        wait_drained();
        repeat (2) @(negedge clk);
        check(map_err == 1'b1, "R8", "error flag sticky", map_err, 1);
        check(go_seen == 8, "R7", "new transfer after stop", go_seen, 8);

        // R9: broadcast write enable
        @(posedge clk); #1 bcast_strobe = 1'b1; bcast_sel = 2'd2;
        @(posedge clk); #1 bcast_strobe = 1'b0;
        @(negedge clk);
        check(fifo_wen == 4'b0100, "R9", "write enable one-hot", fifo_wen, 4'b0100);
        @(negedge clk);
        check(fifo_wen == 4'b0000, "R9", "write enable idle", fifo_wen, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule